// File: doc/BRIEF.md
# Output-Disable Request Input Detector

This block watches two asynchronous, active-low emergency request pins, A and B. It decides when a request has been accepted and reports it to the rest of the chip. Each pin has its own two-bit acceptance mode. The mode either takes any falling edge as a request, or asks for a low level that stays low for sixteen consecutive samples. Those samples are taken on a strobe derived from the peripheral clock divided by 8, 16 or 128. A free-running prescaler supplies the three strobes, and a two-flop synchronizer conditions each pin before it is examined.

When a pin's request is accepted, the block sets a sticky flag for that pin in a single 16-bit control/status register. While either flag is set, the block drives a request output to the tri-state logic that floats the timer outputs. It also raises an interrupt when the enable bit is set. Only hardware can set a flag. Software clears a flag by reading it as 1 and then writing 0 to it. In a sampled-level mode the clear also needs the pin to have been seen high on a sample strobe since the flag was set. The register is reached through a simple synchronous read/write bus. Read data is registered.

Top module: `odr_detect`

## Requirements
- R1: Register layout: bit 15 is the pin B flag, bit 12 the pin A flag, bit 8 the interrupt enable, bits 7:6 the pin B mode and bits 1:0 the pin A mode. Bits 14:13, 11:9 and 5:2 always read 0, and writes to them have no effect. A read returns the register word one clock after the read strobe.
- R2: Mode 00 sets the pin's flag on a falling edge of the synchronized pin, so a low pulse of three clocks is accepted.
- R3: Modes 01, 10 and 11 set the pin's flag when 16 consecutive samples, taken at clk/8, clk/16 and clk/128 respectively, are all low. A low run broken by a high sample before the 16th sample does not set the flag.
- R4: Only hardware sets a flag. Writing 1 to a flag bit has no effect on the flag or on the outputs.
- R5: A write of 0 clears a flag only if the flag has been read as 1 since the last register write. Any register write withdraws that permission, so a write of 0 with no prior read leaves the flag set.
- R6: In modes 01 to 11, a clear by R5 succeeds only if a high level has been sampled on the selected strobe since the flag was set. Otherwise the flag stays set.
- R7: irq_o equals, one clock later, the interrupt enable ANDed with the OR of both flags. With the enable at 0, irq_o stays low.
- R8: odis_req_o equals, one clock later, the OR of both flags, whatever the enable bit holds.
- R9: Both mode fields take the value of the first register write after reset. Later writes leave them unchanged, while the enable bit takes every write.
- R10: After reset, the register reads 0x0000, and irq_o and odis_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| req_a_n | input | 1 | Asynchronous active-low request pin A |
| req_b_n | input | 1 | Asynchronous active-low request pin B |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_o | output | 1 | Combined interrupt request |
| odis_req_o | output | 1 | Request to tri-state the timer outputs |

## Verification
A wrong sample counter or a wrong strobe choice shows up as a flag that sets too early, too late or not at all. The bench sees this at odis_req_o a clock after the sixteenth strobe, and in the flag bit on the next read. A wrong clear-permission or high-seen state shows up as a flag that survives, or vanishes, on the read that follows a write of 0. Lost mode locking shows up in the mode bits of the very next read.

// File: rtl/odr_pkg.sv
package odr_pkg;
  localparam int REG_W = 16;

  // field positions in the control/status word
  localparam int FLAG_B_BIT = 15;
  localparam int FLAG_A_BIT = 12;
  localparam int IEN_BIT    = 8;
  localparam int MODE_B_LSB = 6;
  localparam int MODE_A_LSB = 0;

  typedef enum logic [1:0] {
    ACC_EDGE    = 2'b00,
    ACC_DIV_LO  = 2'b01,
    ACC_DIV_MID = 2'b10,
    ACC_DIV_HI  = 2'b11
  } acc_mode_e;
endpackage

// File: rtl/odr_prescale.sv
module odr_prescale #(
  parameter int DIV_LO  = 8,
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 128
) (
  input  logic       clk,
  input  logic       rst,
  output logic [2:0] stb
);
  localparam int CW = (DIV_HI > 1) ? $clog2(DIV_HI) : 1;
  localparam int DIVS [3] = '{DIV_LO, DIV_MID, DIV_HI};

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  // each divider must be a power of two no larger than DIV_HI
  for (genvar g = 0; g < 3; g++) begin : g_stb
    localparam logic [CW-1:0] MASK = CW'(DIVS[g] - 1);
    assign stb[g] = ((cnt_q & MASK) == MASK);
  end
endmodule

// File: rtl/odr_pin_detect.sv
module odr_pin_detect
  import odr_pkg::*;
#(
  parameter int SAMPLES = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      pin_n,
  input  acc_mode_e mode,
  input  logic [2:0] stb,
  output logic      set_evt,
  output logic      clr_ok
);
  localparam int CNT_W = $clog2(SAMPLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLES - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(SAMPLES);

  logic             sync1_q, sync2_q, prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hi_seen_q;
  logic             is_level;
  logic             stb_sel;

  assign is_level = (mode != ACC_EDGE);

  always_comb begin
    case (mode)
      ACC_DIV_LO:  stb_sel = stb[0];
      ACC_DIV_MID: stb_sel = stb[1];
      ACC_DIV_HI:  stb_sel = stb[2];
      default:     stb_sel = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      prev_q  <= 1'b1;
    end else begin
      sync1_q <= pin_n;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  // consecutive-low sample counter, saturating at SAMPLES
  always_ff @(posedge clk) begin
    if (rst || !is_level) begin
      cnt_q <= '0;
    end else if (stb_sel) begin
      if (sync2_q)            cnt_q <= '0;
      else if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign set_evt = is_level ? (stb_sel && !sync2_q && (cnt_q == LAST))
                            : (prev_q && !sync2_q);

  // high level sampled since the last acceptance
  always_ff @(posedge clk) begin
    if (rst)                                hi_seen_q <= 1'b0;
    else if (set_evt)                       hi_seen_q <= 1'b0;
    else if (is_level && stb_sel && sync2_q) hi_seen_q <= 1'b1;
  end

  assign clr_ok = !is_level || hi_seen_q;
endmodule

// File: rtl/odr_regs.sv
module odr_regs
  import odr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [REG_W-1:0] bus_wdata,
  input  logic [1:0]       set_evt,
  input  logic [1:0]       clr_ok,
  output logic [1:0]       flag,
  output logic             ien,
  output acc_mode_e        mode_a,
  output acc_mode_e        mode_b,
  output logic             locked,
  output logic [REG_W-1:0] rdata,
  output logic             irq_o,
  output logic             odis_o
);
  localparam int FLAG_POS [2] = '{FLAG_A_BIT, FLAG_B_BIT};

  logic       wr, rd;
  logic [1:0] arm_q;
  logic [1:0] flag_n, arm_n;
  logic [REG_W-1:0] word;

  assign wr = bus_en && bus_we;
  assign rd = bus_en && !bus_we;

  always_comb begin
    word = '0;
    word[FLAG_B_BIT] = flag[1];
    word[FLAG_A_BIT] = flag[0];
    word[IEN_BIT]    = ien;
    word[MODE_B_LSB +: 2] = mode_b;
    word[MODE_A_LSB +: 2] = mode_a;
  end

  for (genvar i = 0; i < 2; i++) begin : g_flag
    always_comb begin
      flag_n[i] = flag[i];
      arm_n[i]  = arm_q[i];
      if (rd && flag[i]) arm_n[i] = 1'b1;
      if (wr) begin
        arm_n[i] = 1'b0;
        if (!bus_wdata[FLAG_POS[i]] && arm_q[i] && clr_ok[i]) flag_n[i] = 1'b0;
      end
      if (set_evt[i]) flag_n[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag   <= '0;
      arm_q  <= '0;
      ien    <= 1'b0;
      mode_a <= ACC_EDGE;
      mode_b <= ACC_EDGE;
      locked <= 1'b0;
      rdata  <= '0;
      irq_o  <= 1'b0;
      odis_o <= 1'b0;
    end else begin
      flag  <= flag_n;
      arm_q <= arm_n;
      if (wr) begin
        ien    <= bus_wdata[IEN_BIT];
        locked <= 1'b1;
        if (!locked) begin
          mode_a <= acc_mode_e'(bus_wdata[MODE_A_LSB +: 2]);
          mode_b <= acc_mode_e'(bus_wdata[MODE_B_LSB +: 2]);
        end
      end
      rdata  <= word;
      irq_o  <= ien && (|flag);
      odis_o <= |flag;
    end
  end
endmodule

// File: rtl/odr_detect.sv
module odr_detect
  import odr_pkg::*;
#(
  parameter int DIV_LO  = 8,
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 128,
  parameter int SAMPLES = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_a_n,
  input  logic        req_b_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq_o,
  output logic        odis_req_o
);
  logic [2:0] stb;
  logic [1:0] set_evt, clr_ok, flag, pins;
  logic       ien, locked;
  acc_mode_e  mode_a, mode_b;
  acc_mode_e  modes [2];

  assign pins  = {req_b_n, req_a_n};
  assign modes[0] = mode_a;
  assign modes[1] = mode_b;

  odr_prescale #(.DIV_LO(DIV_LO), .DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_pre (
    .clk(clk), .rst(rst), .stb(stb)
  );

  for (genvar i = 0; i < 2; i++) begin : g_pin
    odr_pin_detect #(.SAMPLES(SAMPLES)) u_det (
      .clk(clk), .rst(rst), .pin_n(pins[i]), .mode(modes[i]), .stb(stb),
      .set_evt(set_evt[i]), .clr_ok(clr_ok[i])
    );
  end

  odr_regs u_regs (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .set_evt(set_evt), .clr_ok(clr_ok), .flag(flag), .ien(ien),
    .mode_a(mode_a), .mode_b(mode_b), .locked(locked), .rdata(bus_rdata),
    .irq_o(irq_o), .odis_o(odis_req_o)
  );
endmodule

// File: rtl/odr_detect_chk.sv
module odr_detect_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_en,
  input logic        bus_we,
  input logic [15:0] bus_wdata,
  input logic [1:0]  flag,
  input logic [1:0]  set_evt,
  input logic        ien,
  input logic [1:0]  mode_a,
  input logic [1:0]  mode_b,
  input logic        locked,
  input logic        irq_o,
  input logic        odis_req_o
);
  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == $past(ien && (flag != 2'b00)));
  // R8
  odis_follow_chk: assert property (@(posedge clk) disable iff (rst)
    odis_req_o == $past(flag != 2'b00));
  // R4
  flag_a_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag[0]) |-> $past(set_evt[0]));
  // R4
  flag_b_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag[1]) |-> $past(set_evt[1]));
  // R5
  flag_a_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flag[0]) |-> $past(bus_en && bus_we && !bus_wdata[12]));
  // R5
  flag_b_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flag[1]) |-> $past(bus_en && bus_we && !bus_wdata[15]));
  // R9
  mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
    $past(locked) |-> ($stable(mode_a) && $stable(mode_b)));
endmodule

bind odr_detect odr_detect_chk u_chk (
  .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .flag(flag), .set_evt(set_evt), .ien(ien), .mode_a(mode_a), .mode_b(mode_b),
  .locked(locked), .irq_o(irq_o), .odis_req_o(odis_req_o)
);

// File: tb/odr_detect_bench.sv
module odr_detect_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_a_n = 1'b1, req_b_n = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_o, odis_req_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  odr_detect u_odr_detect (
    .clk(clk), .rst(rst), .req_a_n(req_a_n), .req_b_n(req_b_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .odis_req_o(odis_req_o)
  );

  typedef struct packed {
    logic        pin_b;
    logic [1:0]  mode;
    logic [15:0] low_len;
    logic        accept;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'b00, 16'd3,    1'b1},  // R2 edge A
    '{1'b1, 2'b00, 16'd3,    1'b1},  // R2 edge B
    '{1'b0, 2'b01, 16'd200,  1'b1},  // R3 clk/8 accept
    '{1'b0, 2'b01, 16'd60,   1'b0},  // R3 clk/8 short pulse
    '{1'b1, 2'b10, 16'd400,  1'b1},  // R3 clk/16 accept
    '{1'b1, 2'b10, 16'd200,  1'b0},  // R3 clk/16 short pulse
    '{1'b0, 2'b11, 16'd2400, 1'b1},  // R3 clk/128 accept
    '{1'b1, 2'b11, 16'd1500, 1'b0}   // R3 clk/128 short pulse
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_a_n = 1'b1; req_b_n = 1'b1; bus_en = 1'b0; bus_we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic bus_write(input logic [15:0] v);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_wdata = v;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(output logic [15:0] v);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0;
    @(negedge clk);
    bus_en = 1'b0;
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] rv, fmask, exp_word;

    // R10 reset state
    do_reset();
    idle(2);
    bus_read(rv);
    check("R10 reset word", rv, 16'h0000);
    check("R10 reset irq", {15'd0, irq_o}, 16'h0000);
    check("R10 reset odis", {15'd0, odis_req_o}, 16'h0000);

    // R1 reserved bits read 0, R4 flag bits not set by writing 1
    bus_write(16'hFFFF);
    idle(2);
    bus_read(rv);
    check("R1 reserved zero / R4 write-1 ignored", rv, 16'h01C3);
    check("R4 no odis after write-1", {15'd0, odis_req_o}, 16'h0000);

    // R9 modes locked after first write, enable still writable
    bus_write(16'h0000);
    idle(1);
    bus_read(rv);
    check("R9 mode lock", rv, 16'h00C3);

    // table walk: R2 / R3
    for (int i = 0; i < NV; i++) begin
      do_reset();
      if (VECS[i].pin_b) bus_write(16'h0100 | (16'(VECS[i].mode) << 6));
      else               bus_write(16'h0100 | 16'(VECS[i].mode));
      idle(4);
      if (VECS[i].pin_b) req_b_n = 1'b0; else req_a_n = 1'b0;
      idle(int'(VECS[i].low_len));
      req_a_n = 1'b1; req_b_n = 1'b1;
      idle(20);
      fmask = VECS[i].pin_b ? 16'h8000 : 16'h1000;
      exp_word = 16'h0100 | (VECS[i].pin_b ? (16'(VECS[i].mode) << 6) : 16'(VECS[i].mode))
               | (VECS[i].accept ? fmask : 16'h0000);
      check($sformatf("R2/R3 vec %0d word", i), rv_read_word(), exp_word);
      check($sformatf("R7 vec %0d irq", i), {15'd0, irq_o}, {15'd0, VECS[i].accept});
      check($sformatf("R8 vec %0d odis", i), {15'd0, odis_req_o}, {15'd0, VECS[i].accept});
    end

    // R5 edge mode clearing
    do_reset();
    bus_write(16'h0100);
    req_a_n = 1'b0; idle(3); req_a_n = 1'b1; idle(6);
    check("R7 irq after edge", {15'd0, irq_o}, 16'h0001);
    bus_write(16'h0100);  // no prior read
    idle(1);
    bus_read(rv);
    check("R5 clear without read keeps flag", rv, 16'h1100);
    bus_write(16'h0100);
    idle(2);
    bus_read(rv);
    check("R5 read-then-write-0 clears", rv, 16'h0100);
    check("R7 irq cleared", {15'd0, irq_o}, 16'h0000);

    // R7 enable off, R8 request still raised
    bus_write(16'h0000);
    req_b_n = 1'b0; idle(3); req_b_n = 1'b1; idle(6);
    bus_read(rv);
    check("R7/R8 flag B word", rv, 16'h8000);
    check("R7 no irq when disabled", {15'd0, irq_o}, 16'h0000);
    check("R8 odis regardless of enable", {15'd0, odis_req_o}, 16'h0001);

    // R6 level mode clear needs a high sample
    do_reset();
    bus_write(16'h0101);
    req_a_n = 1'b0;
    idle(200);
    bus_read(rv);
    check("R3 level flag set", rv, 16'h1101);
    bus_write(16'h0101);
    idle(2);
    bus_read(rv);
    check("R6 clear refused while pin low", rv, 16'h1101);
    req_a_n = 1'b1;
    idle(30);
    bus_read(rv);
    bus_write(16'h0101);
    idle(2);
    bus_read(rv);
    check("R6 clear after high sample", rv, 16'h0101);
    check("R8 odis cleared", {15'd0, odis_req_o}, 16'h0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  function automatic logic [15:0] rv_read_word();
    return bus_rdata;
  endfunction
endmodule